// File: doc/BRIEF.md
# Capture/Compare/PWM Timer (16-bit)

A 16-bit up-counter with two compare registers, one capture register and a small byte-wide register port. The counter either advances on a power-of-two division of the system clock or on edges of an external event pin. The mode setting decides what happens when the count meets a compare value. In capture/compare mode the counter runs straight through the match and wraps from 0xFFFF to 0. In PWM mode a match on the second compare value restarts the count from zero and drives a square-ish output whose high time and period come from the two compare values.

Either of two capture pins, on the edge picked by a select bit, freezes the current count into the capture register. Each capture pin and each compare register has its own sticky flag, and an interrupt request is raised whenever a flag is set and its enable bit is set. Software reads and writes all registers one byte at a time through the write/read port. The counter itself can also be loaded, which lets software preset it.

Top module: `mft_timer`

## Requirements
- R1: After reset every register reads 0, `cmp_o` is 0, `flags_o` is 0 and `irq_o` is 0.
- R2: Register 0 holds run (bit 0), PWM mode (bit 1), external clock (bit 2) and a divider exponent N (bits 5:3). When run is set and external clock is clear, the count goes up by one every 2^N system clocks, counting from the write that sets run.
- R3: In capture/compare mode (bit 1 clear) the count keeps going up through a match on either compare value and wraps from 0xFFFF to 0x0000. Each count step taken while the count equals compare 1 inverts `cmp_o`.
- R4: In PWM mode, a count step taken while the count equals compare 2 loads 0 and sets `cmp_o` to 1. A step taken at compare 1 (and not at compare 2) clears `cmp_o`. The period is compare 2 + 1 steps and the high time is compare 1 + 1 steps.
- R5: A count step taken while the count equals compare 1 sets flag bit 2. A step taken at compare 2 sets flag bit 3.
- R6: Compare 1 sits at bytes 4/5 and compare 2 at bytes 6/7 (low, high). The capture register is read-only at bytes 8/9. The active edge of `cap1_i`/`cap2_i` is picked by register 1 bit 0 (1 = rising, 0 = falling). On the active edge, seen after a two-stage synchronizer, the current count is copied into the capture register and flag bit 0 (`cap1_i`) or bit 1 (`cap2_i`) is set.
- R7: A capture-pin edge of the inactive polarity changes neither the capture register nor the flags.
- R8: With external clock set (register 0 bit 2), the count advances once per synchronized edge of `ext_i` of the polarity picked by register 1 bit 1 (1 = rising). Edges of the other polarity do not advance it.
- R9: Flags at byte 3 are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: Register 2 bits 3:0 enable the matching flag bits. `irq_o` is 1 exactly when some flag is set together with its enable.
- R11: The count is at bytes 10/11 (low, high). Writing either byte loads it, and writes take precedence over counting. With run clear the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the byte at `addr_i` |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| cap1_i | input | 1 | Capture pin 1 (asynchronous) |
| cap2_i | input | 1 | Capture pin 2 (asynchronous) |
| ext_i | input | 1 | External count clock/event pin (asynchronous) |
| cmp_o | output | 1 | Compare/PWM output |
| flags_o | output | 4 | Sticky flags: cap1, cap2, cmp1, cmp2 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench counts exact divider steps for two exponents. A design off by one in the prescaler terminal count, or one that counts during the enabling write, reads back a wrong count. The wrap test starts at 0xFFFE with compare 1 at 0xFFFF and compare 2 at 0. A design that stops at a match, or that clears the count in capture/compare mode, shows a count other than 1, and the flags reveal a missed match. The PWM waveform is checked step by step over two periods, which catches a period one step too long or short and a high time set by the wrong register. Captures are tried on both polarities with opposite-edge stimulus in between, and external counting uses full pulses. A design that reacts to both edges ends with double counts or an overwritten capture value.

// File: rtl/mft_pkg.sv
package mft_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int NFLAG  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 4'd0,
    A_EDGE = 4'd1,
    A_IE   = 4'd2,
    A_FLAG = 4'd3,
    A_C1L  = 4'd4,
    A_C1H  = 4'd5,
    A_C2L  = 4'd6,
    A_C2H  = 4'd7,
    A_CPL  = 4'd8,
    A_CPH  = 4'd9,
    A_CNL  = 4'd10,
    A_CNH  = 4'd11
  } mft_addr_e;

  typedef struct packed {
    logic [2:0] div_n;
    logic       ext_clk;
    logic       pwm;
    logic       run;
  } mft_ctrl_t;

  localparam int F_CAP1 = 0;
  localparam int F_CAP2 = 1;
  localparam int F_CMP1 = 2;
  localparam int F_CMP2 = 3;
endpackage

// File: rtl/mft_sync_edge.sv
module mft_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], in_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign edge_o = rise_sel_i ? (sh_q[STAGES-1] & ~prev_q)
                             : (~sh_q[STAGES-1] & prev_q);
endmodule

// File: rtl/mft_prescaler.sv
module mft_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] div_i,
  output logic            tick_o
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pre_q;
  logic [PC_W-1:0] lim;

  always_comb begin
    for (int i = 0; i < PC_W; i++) lim[i] = (i < int'(div_i));
  end

  assign tick_o = en_i && (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (!en_i || tick_o) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/mft_counter.sv
module mft_counter #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwm_i,
  input  logic [CNT_W-1:0]  cmp1_i,
  input  logic [CNT_W-1:0]  cmp2_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              hit1_o,
  output logic              hit2_o,
  output logic              out_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             out_q;
  logic             eq1, eq2;

  assign eq1    = (cnt_q == cmp1_i);
  assign eq2    = (cnt_q == cmp2_i);
  assign hit1_o = tick_i && eq1;
  assign hit2_o = tick_i && eq2;
  assign cnt_o  = cnt_q;
  assign out_o  = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_lo_i) begin
      cnt_q[DATA_W-1:0] <= ld_data_i;
    end else if (ld_hi_i) begin
      cnt_q[CNT_W-1:DATA_W] <= ld_data_i;
    end else if (tick_i) begin
      if (pwm_i && eq2) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
    end else if (tick_i) begin
      if (pwm_i) begin
        if (eq2)      out_q <= 1'b1;
        else if (eq1) out_q <= 1'b0;
      end else if (eq1) begin
        out_q <= ~out_q;
      end
    end
  end
endmodule

// File: rtl/mft_timer.sv
module mft_timer
  import mft_pkg::*;
#(
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cap1_i,
  input  logic              cap2_i,
  input  logic              ext_i,
  output logic              cmp_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic              irq_o
);
  localparam int NSYNC = 3;

  mft_ctrl_t        ctrl_q;
  logic [1:0]       edge_q;
  logic [NFLAG-1:0] ie_q;
  logic [NFLAG-1:0] flags_q;
  logic [CNT_W-1:0] cmp1_q, cmp2_q, cap_q, cnt_q;

  logic [NSYNC-1:0] pin_in, pin_rise, pin_edge;
  logic cap1_ev, cap2_ev, ext_ev;
  logic pre_tick, cnt_tick, hit1, hit2;
  logic wr_ctrl, wr_edge, wr_ie, wr_flag;
  logic wr_c1l, wr_c1h, wr_c2l, wr_c2h, wr_cnl, wr_cnh;

  always_comb begin
    wr_ctrl = wr_en_i && (addr_i == A_CTRL);
    wr_edge = wr_en_i && (addr_i == A_EDGE);
    wr_ie   = wr_en_i && (addr_i == A_IE);
    wr_flag = wr_en_i && (addr_i == A_FLAG);
    wr_c1l  = wr_en_i && (addr_i == A_C1L);
    wr_c1h  = wr_en_i && (addr_i == A_C1H);
    wr_c2l  = wr_en_i && (addr_i == A_C2L);
    wr_c2h  = wr_en_i && (addr_i == A_C2H);
    wr_cnl  = wr_en_i && (addr_i == A_CNL);
    wr_cnh  = wr_en_i && (addr_i == A_CNH);
  end

  // pin order: cap1, cap2, ext
  assign pin_in   = {ext_i, cap2_i, cap1_i};
  assign pin_rise = {edge_q[1], edge_q[0], edge_q[0]};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    mft_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_i      (pin_in[g]),
      .rise_sel_i(pin_rise[g]),
      .edge_o    (pin_edge[g])
    );
  end

  assign cap1_ev = pin_edge[0];
  assign cap2_ev = pin_edge[1];
  assign ext_ev  = pin_edge[2];

  mft_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl_q.run && !ctrl_q.ext_clk),
    .div_i (ctrl_q.div_n),
    .tick_o(pre_tick)
  );

  assign cnt_tick = ctrl_q.run && (ctrl_q.ext_clk ? ext_ev : pre_tick);

  mft_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cnt_tick),
    .pwm_i    (ctrl_q.pwm),
    .cmp1_i   (cmp1_q),
    .cmp2_i   (cmp2_q),
    .ld_lo_i  (wr_cnl),
    .ld_hi_i  (wr_cnh),
    .ld_data_i(wdata_i),
    .cnt_o    (cnt_q),
    .hit1_o   (hit1),
    .hit2_o   (hit2),
    .out_o    (cmp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      edge_q <= '0;
      ie_q   <= '0;
      cmp1_q <= '0;
      cmp2_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= mft_ctrl_t'(wdata_i[5:0]);
      if (wr_edge) edge_q <= wdata_i[1:0];
      if (wr_ie)   ie_q   <= wdata_i[NFLAG-1:0];
      if (wr_c1l)  cmp1_q[DATA_W-1:0]     <= wdata_i;
      if (wr_c1h)  cmp1_q[CNT_W-1:DATA_W] <= wdata_i;
      if (wr_c2l)  cmp2_q[DATA_W-1:0]     <= wdata_i;
      if (wr_c2h)  cmp2_q[CNT_W-1:DATA_W] <= wdata_i;
    end
  end

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~(wr_flag ? wdata_i[NFLAG-1:0] : '0))
               | {hit2, hit1, cap2_ev, cap1_ev};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cap_q <= '0;
    else if (cap1_ev || cap2_ev) cap_q <= cnt_q;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & ie_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o = {2'b00, ctrl_q};
      A_EDGE: rdata_o = {6'b0, edge_q};
      A_IE:   rdata_o = {4'b0, ie_q};
      A_FLAG: rdata_o = {4'b0, flags_q};
      A_C1L:  rdata_o = cmp1_q[DATA_W-1:0];
      A_C1H:  rdata_o = cmp1_q[CNT_W-1:DATA_W];
      A_C2L:  rdata_o = cmp2_q[DATA_W-1:0];
      A_C2H:  rdata_o = cmp2_q[CNT_W-1:DATA_W];
      A_CPL:  rdata_o = cap_q[DATA_W-1:0];
      A_CPH:  rdata_o = cap_q[CNT_W-1:DATA_W];
      A_CNL:  rdata_o = cnt_q[DATA_W-1:0];
      A_CNH:  rdata_o = cnt_q[CNT_W-1:DATA_W];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mft_timer_chk.sv
module mft_timer_chk
  import mft_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NFLAG-1:0]  flags_o,
  input logic              irq_o,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp1_q
);
  logic cnt_wr, flag_wr;
  assign cnt_wr  = wr_en_i && (addr_i == A_CNL || addr_i == A_CNH);
  assign flag_wr = wr_en_i && (addr_i == A_FLAG);

  // R10
  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_o != '0));

  // R9
  a_r9_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R11
  a_r11_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_wr) |=> $stable(cnt_q));

  // R2
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 16'd1 || cnt_q == '0));

  // R5
  a_r5_cmp1_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_CMP1]) |-> $past(cnt_q == cmp1_q));
endmodule

bind mft_timer mft_timer_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .flags_o(flags_o),
  .irq_o  (irq_o),
  .run_q  (ctrl_q.run),
  .cnt_q  (cnt_q),
  .cmp1_q (cmp1_q)
);

// File: tb/mft_timer_tb_top.sv
module mft_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       cap1_i = 1'b0, cap2_i = 1'b0, ext_i = 1'b0;
  logic       cmp_o, irq_o;
  logic [3:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  mft_timer dut_i (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en_i = 0; cap1_i = 0; cap2_i = 0; ext_i = 0;
    @(negedge clk_i); rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  // called at a negedge, returns one negedge later
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    wr_en_i = 0; addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      check("R1 register", {8'h0, v}, 16'h0);
    end
    check("R1 cmp_o", {15'b0, cmp_o}, 16'h0);
    check("R1 flags", {12'b0, flags_o}, 16'h0);
    check("R1 irq", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_prescale(input logic [2:0] n, input int m, input logic [15:0] exp);
    logic [15:0] c;
    do_reset();
    wr(4'd0, {2'b0, n, 3'b001});
    repeat (m) @(negedge clk_i);
    wr(4'd0, 8'h00);
    rd16(4'd10, c);
    check("R2 prescaled count", c, exp);
    repeat (5) @(negedge clk_i);
    rd16(4'd10, c);
    check("R11 hold while stopped", c, exp);
  endtask

  task automatic t_wrap();
    logic [15:0] c;
    do_reset();
    wr(4'd10, 8'hFE); wr(4'd11, 8'hFF);
    rd16(4'd10, c);
    check("R11 count load", c, 16'hFFFE);
    wr(4'd4, 8'hFF); wr(4'd5, 8'hFF);
    wr(4'd0, 8'h01);
    repeat (2) @(negedge clk_i);
    wr(4'd0, 8'h00);
    rd16(4'd10, c);
    check("R3 wrap and count past match", c, 16'h0001);
    check("R3 cmp_o toggled", {15'b0, cmp_o}, 16'h1);
    check("R5 compare flags", {12'b0, flags_o}, 16'h000C);
  endtask

  task automatic t_pwm();
    do_reset();
    wr(4'd4, 8'd2); wr(4'd6, 8'd5);
    wr(4'd0, 8'h03);
    for (int j = 1; j <= 14; j++) begin
      logic e;
      @(negedge clk_i);
      e = (j < 6) ? 1'b0 : (((j - 6) % 6) < 3);
      check($sformatf("R4 pwm step %0d", j), {15'b0, cmp_o}, {15'b0, e});
    end
    check("R5 flags in pwm", {12'b0, flags_o}, 16'h000C);
  endtask

  task automatic t_capture();
    logic [15:0] c;
    logic [7:0] v;
    do_reset();
    wr(4'd1, 8'h01);
    wr(4'd10, 8'h34); wr(4'd11, 8'h12);
    cap1_i = 1; repeat (4) @(negedge clk_i);
    rd16(4'd8, c);
    check("R6 rising capture value", c, 16'h1234);
    check("R6 cap1 flag", {12'b0, flags_o}, 16'h0001);
    check("R10 irq masked", {15'b0, irq_o}, 16'h0);
    wr(4'd2, 8'h01);
    check("R10 irq enabled", {15'b0, irq_o}, 16'h1);
    wr(4'd3, 8'h00);
    check("R9 write 0 keeps flag", {12'b0, flags_o}, 16'h0001);
    wr(4'd3, 8'h0F);
    check("R9 write 1 clears flag", {12'b0, flags_o}, 16'h0000);
    check("R10 irq drops", {15'b0, irq_o}, 16'h0);
    wr(4'd10, 8'h78); wr(4'd11, 8'h56);
    cap1_i = 0; repeat (4) @(negedge clk_i);
    rd16(4'd8, c);
    check("R7 falling ignored value", c, 16'h1234);
    check("R7 falling ignored flags", {12'b0, flags_o}, 16'h0000);
    cap2_i = 1; repeat (4) @(negedge clk_i);
    rd16(4'd8, c);
    check("R6 cap2 capture value", c, 16'h5678);
    check("R6 cap2 flag", {12'b0, flags_o}, 16'h0002);
    wr(4'd1, 8'h00);
    wr(4'd10, 8'hBC); wr(4'd11, 8'h9A);
    cap1_i = 1; repeat (4) @(negedge clk_i);
    rd(4'd3, v);
    check("R7 rising ignored in falling mode", {8'h0, v}, 16'h0002);
    cap2_i = 0; repeat (4) @(negedge clk_i);
    rd16(4'd8, c);
    check("R6 falling capture value", c, 16'h9ABC);
  endtask

  task automatic t_ext();
    logic [15:0] c;
    do_reset();
    wr(4'd1, 8'h02);
    wr(4'd0, 8'h05);
    for (int p = 0; p < 5; p++) begin
      ext_i = 1; repeat (3) @(negedge clk_i);
      ext_i = 0; repeat (3) @(negedge clk_i);
    end
    repeat (3) @(negedge clk_i);
    wr(4'd0, 8'h00);
    rd16(4'd10, c);
    check("R8 rising external edges", c, 16'd5);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_prescale(3'd0, 9, 16'd10);
    t_prescale(3'd2, 19, 16'd5);
    t_wrap();
    t_pwm();
    t_capture();
    t_ext();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule